// File: doc/BRIEF.md
# Program Counter and Return Stack

This block produces the address of the next instruction for a small 4-bit controller core. Each clock cycle it takes one already decoded instruction: a class code, up to two opcode bytes and the current status flag. From these it moves a 12-bit program counter through a 3072-word program space. That program space runs from 000h to BFFh.

Calls and interrupts save their return address on a 13-level return stack. Returns take the address back off that stack. An interrupt also saves the four condition flags together with the return address. Return-from-interrupt restores those flags and sets the interrupt enable again.

Software can place the stack pointer at any starting level. Two sticky flags record a push onto a full stack and a pop from an empty stack. The core around this block fetches instructions, decodes them and ranks interrupt requests. This block only acts on a request that has already been chosen.

Top module: `pcstk_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `pc` to 000h, `sp` to 13 (empty), `ie` to 1, and `flags_out`, `flags_load`, `stk_ovf` and `stk_unf` to 0.
- R2: Class code 0 adds 1 to `pc` and class code 1 adds 2. Every increment wraps modulo 3072, so BFFh+1 gives 000h and BFEh+2 gives 000h.
- R3: A short branch (class 2) with `status_flag` at 1 replaces bits 5..0 of `pc`+1 with `op_byte0[5:0]`. With the flag at 0, `pc` advances by 1.
- R4: A long branch (class 3) with the flag at 1 loads `{op_byte0[3:0], op_byte1}`. With the flag at 0, or with a target above BFFh, `pc` advances by 2.
- R5: A short call (class 4) pushes `pc`+1 and jumps to 8n+6, where n is `op_byte0[3:0]`. When n is 0 it jumps to 086h instead.
- R6: A long call (class 5) pushes `pc`+2 and jumps to `{1'b0, op_byte0[2:0], op_byte1}`, so its target is never above 7FFh.
- R7: A push lowers `sp` by one and writes at the new level. A return (class 6) loads `pc` from level `sp`, raises `sp` by one, and leaves `flags_out` and `ie` unchanged.
- R8: A return from interrupt (class 7) pops the same way as a return. It also loads the saved flags into `flags_out`, pulses `flags_load` for one cycle and sets `ie` to 1.
- R9: When `ie` is 1 and `irq_req` is high with `irq_src` in the range 0..4, the presented instruction is dropped. The block then pushes `pc` together with `flags_in`, clears `ie` and jumps to the vector for that source: 002h, 006h, 008h, 00Ah or 00Ch, in source order. Source codes 5..7, or `ie` at 0, leave the instruction to execute normally.
- R10: With `sp_wr` high, `sp` takes `sp_wdata`, and any value above 13 is clamped to 13. In that cycle `pc` advances by 1, the class code is ignored and no interrupt is taken.
- R11: A push with `sp` at 0 stores nothing, keeps `sp` at 0 and sets the sticky `stk_ovf`, but the jump still happens. A pop with `sp` at 13 sets the sticky `stk_unf`, leaves `sp` unchanged and advances `pc` by 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_class | input | 3 | Decoded class: 0 step1, 1 step2, 2 short branch, 3 long branch, 4 short call, 5 long call, 6 return, 7 return from interrupt |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte |
| status_flag | input | 1 | Branch condition flag |
| flags_in | input | 4 | Current condition flags, saved on interrupt entry |
| irq_req | input | 1 | Chosen interrupt request |
| irq_src | input | 3 | Source of the request |
| sp_wr | input | 1 | Stack pointer write |
| sp_wdata | input | 4 | Stack pointer write value |
| pc | output | 12 | Program counter |
| sp | output | 4 | Stack pointer (13 = empty) |
| ie | output | 1 | Interrupt enable |
| flags_out | output | 4 | Flags restored by the last return from interrupt |
| flags_load | output | 1 | One-cycle pulse when `flags_out` is reloaded |
| stk_ovf | output | 1 | Sticky push-on-full flag |
| stk_unf | output | 1 | Sticky pop-on-empty flag |

## Verification
Some properties are checked by assertions on every cycle:
- `pc` never leaves the 3072-word space.
- `sp` never passes 13.
- A successful push or pop moves `sp` by exactly one.
- The sticky error flags never clear outside reset.
- A taken interrupt clears `ie` and lands on an even vector below 010h.

Other behaviour only the bench scenarios can show, by comparing against an independent model:
- The actual jump targets.
- Whether the correct return address and flags come back after nested calls and interrupts.
- That clamped pointer writes and ignored interrupt sources behave as required.

// File: rtl/pcstk_pkg.sv
// Package: shared sizes, class codes, stack entry type and address helpers
// for the program counter / return stack block.
package pcstk_pkg;
    localparam int PC_W      = 12;
    localparam int ROM_WORDS = 3072;
    localparam int STK_DEPTH = 13;
    localparam int SP_W      = $clog2(STK_DEPTH + 1);
    localparam int FLG_W     = 4;
    localparam int SRC_W     = 3;
    localparam int NUM_VEC   = 5;

    typedef enum logic [2:0] {
        OP_STEP1 = 3'd0,
        OP_STEP2 = 3'd1,
        OP_SBR   = 3'd2,
        OP_LBR   = 3'd3,
        OP_SCALL = 3'd4,
        OP_LCALL = 3'd5,
        OP_RET   = 3'd6,
        OP_RETI  = 3'd7
    } op_e;

    typedef struct packed {
        logic [FLG_W-1:0] flg;
        logic [PC_W-1:0]  ret;
    } stk_ent_t;

    // Add 1 or 2 to an address, wrapping at the top of program space.
    function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] a,
                                                 input logic [1:0] d);
        logic [PC_W:0] s;
        s = {1'b0, a} + {{(PC_W - 1){1'b0}}, d};
        if (s >= (PC_W + 1)'(ROM_WORDS))
            s = s - (PC_W + 1)'(ROM_WORDS);
        return s[PC_W-1:0];
    endfunction

    // Interrupt vector for a source; top bit flags a known source.
    function automatic logic [PC_W:0] irq_vector(input logic [SRC_W-1:0] src);
        logic [PC_W:0] v;
        if (int'(src) >= NUM_VEC)
            v = '0;
        else if (src == '0)
            v = {1'b1, PC_W'(2)};
        else
            v = {1'b1, PC_W'(4 + 2 * int'(src))};
        return v;
    endfunction
endpackage

// File: rtl/pcstk_target.sv
// Module: pcstk_target
// Purely combinational next-address logic for one decoded instruction.
// Assumes pc lies inside program space. It reports whether the instruction
// pushes (and what) or pops; the caller decides what wins in the cycle.
module pcstk_target
    import pcstk_pkg::*;
(
    input  logic [PC_W-1:0] pc_cur,
    input  logic [2:0]      op_class,
    input  logic [7:0]      byte0,
    input  logic [7:0]      byte1,
    input  logic            sf,
    output logic [PC_W-1:0] pc_nxt,
    output logic            push_req,
    output logic [PC_W-1:0] push_ret,
    output logic            pop_req,
    output logic            pop_reti
);
    logic [PC_W-1:0] inc1;
    logic [PC_W-1:0] inc2;
    logic [PC_W-1:0] lbr_tgt;
    logic [3:0]      scall_n;
    op_e             op;

    assign inc1    = pc_step(pc_cur, 2'd1);
    assign inc2    = pc_step(pc_cur, 2'd2);
    assign lbr_tgt = {byte0[3:0], byte1};
    assign scall_n = byte0[3:0];
    assign op      = op_e'(op_class);

    // Select the next address and the stack action for the class.
    always_comb begin
        pc_nxt   = inc1;
        push_req = 1'b0;
        push_ret = inc1;
        pop_req  = 1'b0;
        pop_reti = 1'b0;
        case (op)
            OP_STEP1: pc_nxt = inc1;
            OP_STEP2: pc_nxt = inc2;
            OP_SBR:   pc_nxt = sf ? {inc1[PC_W-1:6], byte0[5:0]} : inc1;
            OP_LBR:   pc_nxt = (sf && (int'(lbr_tgt) < ROM_WORDS)) ? lbr_tgt : inc2;
            OP_SCALL: begin
                pc_nxt   = (scall_n == 4'd0) ? PC_W'(12'h086)
                         : ({{(PC_W - 7){1'b0}}, scall_n, 3'b000} + PC_W'(6));
                push_req = 1'b1;
                push_ret = inc1;
            end
            OP_LCALL: begin
                pc_nxt   = {1'b0, byte0[2:0], byte1};
                push_req = 1'b1;
                push_ret = inc2;
            end
            OP_RET:   pop_req = 1'b1;
            OP_RETI: begin
                pop_req  = 1'b1;
                pop_reti = 1'b1;
            end
            default:  pc_nxt = inc1;
        endcase
    end
endmodule

// File: rtl/pcstk_stack.sv
// Module: pcstk_stack
// Return stack of DEPTH entries with a software-loadable pointer.
// The pointer counts down on push; DEPTH means empty and 0 means full.
// Assumes push and pop are never requested in the same cycle. A pointer
// load takes precedence over both.
module pcstk_stack
    import pcstk_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  stk_ent_t       wr_ent,
    input  logic           sp_ld,
    input  logic [PW-1:0]  sp_ld_val,
    output stk_ent_t       rd_ent,
    output logic           empty,
    output logic [PW-1:0]  sp_q,
    output logic           ovf_q,
    output logic           unf_q
);
    stk_ent_t       mem [DEPTH];
    logic           full;
    logic           do_push;
    logic           do_pop;
    logic [PW-1:0]  wr_idx;

    assign full    = (sp_q == '0);
    assign empty   = (int'(sp_q) >= DEPTH);
    assign do_push = push && !sp_ld && !full;
    assign do_pop  = pop && !sp_ld && !empty;
    assign wr_idx  = sp_q - PW'(1);
    assign rd_ent  = empty ? '0 : mem[sp_q];

    // Store the pushed entry at the level just below the pointer.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_idx] <= wr_ent;
    end

    // Maintain the pointer: reset to empty, load with clamp, step on push/pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= PW'(DEPTH);
        else if (sp_ld)
            sp_q <= (int'(sp_ld_val) > DEPTH) ? PW'(DEPTH) : sp_ld_val;
        else if (do_push)
            sp_q <= sp_q - PW'(1);
        else if (do_pop)
            sp_q <= sp_q + PW'(1);
    end

    // Record sticky push-on-full and pop-on-empty errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (push && !sp_ld && full)
                ovf_q <= 1'b1;
            if (pop && !sp_ld && empty)
                unf_q <= 1'b1;
        end
    end

    // R10
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sp_q) <= DEPTH);
    // R7
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !sp_ld && sp_q != '0) |=> (sp_q == $past(sp_q) - PW'(1)));
    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !sp_ld && int'(sp_q) < DEPTH) |=> (sp_q == $past(sp_q) + PW'(1)));
    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    // R11
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |=> unf_q);
    // R7
    no_push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/pcstk_top.sv
// Module: pcstk_top
// Program counter and return stack. Each cycle one decoded instruction is
// applied, unless a stack pointer write or an accepted interrupt overrides
// it. Priority: reset, pointer write, interrupt, instruction.
// Assumes a ranked interrupt request arrives with its source code.
module pcstk_top
    import pcstk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_class,
    input  logic [7:0]       op_byte0,
    input  logic [7:0]       op_byte1,
    input  logic             status_flag,
    input  logic [FLG_W-1:0] flags_in,
    input  logic             irq_req,
    input  logic [SRC_W-1:0] irq_src,
    input  logic             sp_wr,
    input  logic [SP_W-1:0]  sp_wdata,
    output logic [PC_W-1:0]  pc,
    output logic [SP_W-1:0]  sp,
    output logic             ie,
    output logic [FLG_W-1:0] flags_out,
    output logic             flags_load,
    output logic             stk_ovf,
    output logic             stk_unf
);
    logic [PC_W-1:0]  pc_q;
    logic             ie_q;
    logic [PC_W-1:0]  tgt_pc;
    logic             t_push;
    logic [PC_W-1:0]  t_push_ret;
    logic             t_pop;
    logic             t_reti;
    logic [PC_W:0]    vec;
    logic             take_irq;
    logic             s_push;
    logic             s_pop;
    stk_ent_t         s_wr;
    stk_ent_t         s_rd;
    logic             s_empty;
    logic             pop_ok;

    pcstk_target u_target (
        .pc_cur   (pc_q),
        .op_class (op_class),
        .byte0    (op_byte0),
        .byte1    (op_byte1),
        .sf       (status_flag),
        .pc_nxt   (tgt_pc),
        .push_req (t_push),
        .push_ret (t_push_ret),
        .pop_req  (t_pop),
        .pop_reti (t_reti)
    );

    // Arbitrate between pointer write, interrupt entry and the instruction.
    always_comb begin
        vec      = irq_vector(irq_src);
        take_irq = !sp_wr && ie_q && irq_req && vec[PC_W];
        s_push   = take_irq || (!sp_wr && t_push);
        s_pop    = !sp_wr && !take_irq && t_pop;
        s_wr     = take_irq ? stk_ent_t'{flg: flags_in, ret: pc_q}
                            : stk_ent_t'{flg: '0, ret: t_push_ret};
        pop_ok   = s_pop && !s_empty;
    end

    pcstk_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (s_push),
        .pop       (s_pop),
        .wr_ent    (s_wr),
        .sp_ld     (sp_wr),
        .sp_ld_val (sp_wdata),
        .rd_ent    (s_rd),
        .empty     (s_empty),
        .sp_q      (sp),
        .ovf_q     (stk_ovf),
        .unf_q     (stk_unf)
    );

    // Update the program counter from the winning source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (sp_wr)
            pc_q <= pc_step(pc_q, 2'd1);
        else if (take_irq)
            pc_q <= vec[PC_W-1:0];
        else if (pop_ok)
            pc_q <= s_rd.ret;
        else
            pc_q <= tgt_pc;
    end

    // Track interrupt enable and restore flags on return from interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q       <= 1'b1;
            flags_out  <= '0;
            flags_load <= 1'b0;
        end else begin
            flags_load <= 1'b0;
            if (take_irq)
                ie_q <= 1'b0;
            else if (pop_ok && t_reti) begin
                ie_q       <= 1'b1;
                flags_out  <= s_rd.flg;
                flags_load <= 1'b1;
            end
        end
    end

    assign pc = pc_q;
    assign ie = ie_q;

    // R2
    pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pc_q) < ROM_WORDS);
    // R9
    irq_ie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !ie_q);
    // R9
    irq_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (pc_q[PC_W-1:4] == '0 && !pc_q[0] && pc_q != '0));
    // R6
    lcall_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_wr && !take_irq && op_class == 3'd5) |=> !pc_q[PC_W-1]);
    // R8
    fload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_load |-> ie_q);
endmodule

// File: tb/pcstk_tb.sv
`timescale 1ns/1ps
module pcstk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_class = '0;
    logic [7:0]  op_byte0 = '0;
    logic [7:0]  op_byte1 = '0;
    logic        status_flag = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_src = '0;
    logic        sp_wr = 1'b0;
    logic [3:0]  sp_wdata = '0;
    logic [11:0] pc;
    logic [3:0]  sp;
    logic        ie;
    logic [3:0]  flags_out;
    logic        flags_load;
    logic        stk_ovf;
    logic        stk_unf;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    int       m_pc, m_sp;
    int       m_ret [13];
    int       m_flgs [13];
    bit       m_ie, m_fload, m_ovf, m_unf;
    int       m_flg;

    always #4 clk = ~clk;

    pcstk_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .op_byte0(op_byte0),
        .op_byte1(op_byte1), .status_flag(status_flag), .flags_in(flags_in),
        .irq_req(irq_req), .irq_src(irq_src), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
        .pc(pc), .sp(sp), .ie(ie), .flags_out(flags_out), .flags_load(flags_load),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    function automatic int inc(int a, int d);
        return (a + d) % 3072;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_pc = 0; m_sp = 13; m_ie = 1; m_flg = 0; m_fload = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic m_push(int r, int f);
        if (m_sp == 0) m_ovf = 1;
        else begin
            m_sp--;
            m_ret[m_sp] = r;
            m_flgs[m_sp] = f;
        end
    endtask

    task automatic m_pop(bit reti);
        if (m_sp >= 13) begin
            m_unf = 1;
            m_pc = inc(m_pc, 1);
        end else begin
            m_pc = m_ret[m_sp];
            if (reti) begin
                m_flg = m_flgs[m_sp];
                m_ie = 1;
                m_fload = 1;
            end
            m_sp++;
        end
    endtask

    // Apply the requirements to the model for one cycle of stimulus.
    task automatic m_step(int op, int b0, int b1, bit sf, bit irq, int src,
                          int fl, bit spw, int spv);
        int t;
        m_fload = 0;
        if (spw) begin
            m_pc = inc(m_pc, 1);
            m_sp = (spv > 13) ? 13 : spv;
            return;
        end
        if (irq && m_ie && src <= 4) begin
            m_push(m_pc, fl);
            m_pc = (src == 0) ? 2 : 4 + 2 * src;
            m_ie = 0;
            return;
        end
        case (op)
            0: m_pc = inc(m_pc, 1);
            1: m_pc = inc(m_pc, 2);
            2: begin
                t = inc(m_pc, 1);
                m_pc = sf ? ((t & 12'hFC0) | (b0 & 6'h3F)) : t;
            end
            3: begin
                t = ((b0 & 15) << 8) | b1;
                m_pc = (sf && t < 3072) ? t : inc(m_pc, 2);
            end
            4: begin
                m_push(inc(m_pc, 1), 0);
                m_pc = ((b0 & 15) == 0) ? 12'h086 : 8 * (b0 & 15) + 6;
            end
            5: begin
                m_push(inc(m_pc, 2), 0);
                m_pc = ((b0 & 7) << 8) | b1;
            end
            6: m_pop(0);
            default: m_pop(1);
        endcase
    endtask

    task automatic compare(string tag);
        chk(tag, "pc", int'(pc), m_pc);
        chk(tag, "sp", int'(sp), m_sp);
        chk(tag, "ie", int'(ie), int'(m_ie));
        chk(tag, "flags_out", int'(flags_out), m_flg);
        chk(tag, "flags_load", int'(flags_load), int'(m_fload));
        chk(tag, "stk_ovf", int'(stk_ovf), int'(m_ovf));
        chk(tag, "stk_unf", int'(stk_unf), int'(m_unf));
    endtask

    // Drive one cycle at the falling edge, then compare at the next one.
    task automatic run(string tag, int op, int b0 = 0, int b1 = 0, bit sf = 0,
                       bit irq = 0, int src = 0, int fl = 0, bit spw = 0, int spv = 0);
        op_class = 3'(op); op_byte0 = 8'(b0); op_byte1 = 8'(b1);
        status_flag = sf; irq_req = irq; irq_src = 3'(src); flags_in = 4'(fl);
        sp_wr = spw; sp_wdata = 4'(spv);
        m_step(op, b0, b1, sf, irq, src, fl, spw, spv);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        run("R2", 0);
        run("R2", 1);
        run("R4", 3, 8'hCB, 8'hFF, 1);       // to BFF
        run("R2", 0);                        // wrap to 000
        run("R4", 3, 8'hCB, 8'hFE, 1);       // to BFE
        run("R2", 1);                        // wrap to 000
        run("R4", 3, 8'hCC, 8'h00, 1);       // C00 out of range
        run("R4", 3, 8'hC1, 8'h23, 0);       // not taken
        run("R4", 3, 8'hC1, 8'h23, 1);
        run("R3", 2, 8'h15, 0, 1);
        run("R3", 2, 8'h3F, 0, 0);
        run("R5", 4, 8'hE0);                 // n=0 -> 086
        run("R7", 6);
        run("R5", 4, 8'hEF);                 // n=15 -> 07E
        run("R6", 5, 8'h47, 8'hFF);          // -> 7FF
        run("R9", 0, 0, 0, 0, 1, 5, 4'hA);   // source 5 ignored
        run("R9", 1, 0, 0, 0, 1, 2, 4'h9);   // timer B -> 008
        run("R9", 0, 0, 0, 0, 1, 0, 4'h3);   // ie clear: not taken
        run("R8", 7);
        run("R7", 6);
        run("R7", 6);
        run("R10", 0, 0, 0, 0, 1, 1, 0, 1, 15);  // clamp, irq blocked
        run("R10", 6, 0, 0, 0, 0, 0, 0, 1, 0);   // pointer to full
        run("R11", 4, 8'hE3);                    // push on full
        run("R11", 5, 8'h41, 8'h10);
        run("R10", 0, 0, 0, 0, 0, 0, 0, 1, 13);
        run("R11", 6);                           // pop on empty
        // Each vector in turn
        for (int s = 0; s < 5; s++) begin
            run("R9", 0, 0, 0, 0, 1, s, s + 1);
            run("R8", 7);
        end
        // Random mix against the model
        void'($urandom(32'h5EED_0C0D));
        for (int i = 0; i < 3000; i++) begin
            int  op, b0, b1, src, fl, spv;
            bit  sf, irq, spw;
            op  = int'($urandom_range(0, 7));
            b0  = int'($urandom_range(0, 255));
            b1  = int'($urandom_range(0, 255));
            sf  = 1'($urandom_range(0, 1));
            irq = ($urandom_range(0, 7) == 0);
            src = int'($urandom_range(0, 7));
            fl  = int'($urandom_range(0, 15));
            spw = ($urandom_range(0, 29) == 0);
            spv = int'($urandom_range(0, 15));
            if (i % 500 == 0) begin
                rst_n = 1'b0;
                m_reset();
                @(negedge clk);
                compare("R1");
                rst_n = 1'b1;
            end
            run("R2", op, b0, b1, sf, irq, src, fl, spw, spv);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule